// File: doc/BRIEF.md
# Handshake Link Flush Sequencer

This block runs the host side of a flush on a three-wire serial link. The guest device owns the link clock. The host owns the acknowledge line and drives the data line through an open-drain driver. A flush moves the link through a four-phase handshake:

- the guest lowering the clock takes the link from phase 0 to phase 1;
- the host lowering acknowledge takes it to phase 2;
- the guest raising the clock takes it to phase 3;
- the host raising acknowledge returns it to phase 0.

A `startFlush` pulse makes the host the flusher. The host pulls data low and keeps it low for a fixed number of complete handshake cycles. On the next clock fall it lets data go. From there it carries on as the flushee.

A `startFlushee` pulse makes the host take part in a flush that the guest started. In the flushee role the host keeps handshaking and looks at data in every phase 3. When data is high there, the host raises acknowledge, pulses `done` and returns to idle.

Every wait for a clock level is limited to a fixed number of system-clock polls. If the limit runs out, the block pulses `timeout` and puts the link back in its idle levels. The link clock and data inputs each pass through a two-flop synchroniser before any decision is made on them.

Top module: `hlf_top`

## Requirements
- R1: Out of reset, `linkAck` is 1, `linkDataLow` is 0, and `busy`, `done` and `timeout` are all 0.
- R2: The sampling edge of a `startFlush` pulse taken while idle sets `linkDataLow` to 1, and `busy` to 1. `linkDataLow` stays 1 through FLUSH_CYCLES complete handshake cycles.
- R3: After the last of those cycles, `linkDataLow` stays 1 until the guest next lowers the clock. It then drops to 0 before `linkAck` falls. The host lowers `linkAck` one cycle later than in a normal phase, four cycles after the clock change.
- R4: In the flushee role, phase 3 with data low is answered by raising `linkAck` with no `done`. The handshake then continues.
- R5: Phase 3 with data high ends the flush. On the same clock edge, `linkAck` rises and a `done` pulse of exactly one cycle is given, and `busy` returns to 0 at that edge.
- R6: A flushee sequence started by `startFlushee` never sets `linkDataLow`. It needs exactly N+1 handshakes when the guest holds data low in the first N phase-3 samples.
- R7: A wait for a clock level that lasts POLL_LIMIT cycles ends in a one-cycle `timeout` pulse, with `linkAck` at 1, `linkDataLow` at 0 and `busy` at 0.
  - Waiting in phase 0 after start, `timeout` is first seen POLL_LIMIT+1 falling system-clock edges after the edge on which `startFlush` was driven.
  - Waiting in phase 2, it is first seen POLL_LIMIT falling edges after `linkAck` is seen low.
- R8: With two synchroniser stages, a clock change made midway through a system-clock cycle is answered on `linkAck` on the third rising edge after the change, never earlier. This applies while the block is waiting on that level.
- R9: `startFlush` and `startFlushee` pulses that arrive while `busy` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startFlush | input | 1 | Pulse: begin a flush with the host as flusher |
| startFlushee | input | 1 | Pulse: follow a flush that the guest started |
| linkClk | input | 1 | Link clock driven by the guest (asynchronous) |
| linkData | input | 1 | Level sensed on the open-drain data line (asynchronous) |
| linkAck | output | 1 | Acknowledge line driven by the host |
| linkDataLow | output | 1 | Enable of the data pull-down; 0 leaves the line to the pull-up |
| busy | output | 1 | A flush sequence is in progress |
| done | output | 1 | One-cycle pulse when the link is back in phase 0 |
| timeout | output | 1 | One-cycle pulse when a clock wait runs out |

## Verification
Host-started flushes are run with zero to three extra guest-held data-low handshakes after the host lets data go. This separates an early or late release from a correct one, and shows whether the host follows the guest's hold instead of stopping at its own count. Guest-started flushes are run with zero to four data-low handshakes before data rises. These show that the handshake count tracks the data level and that the host never pulls data. One of these runs carries a stray start pulse in its middle. Two timeout cases, one stuck in phase 0 and one stuck in phase 2, are timed to the exact cycle. Every acknowledge edge is checked against the synchroniser latency.

// File: rtl/hlf_pkg.sv
package hlf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_F_LO  = 3'd1,
    ST_F_HI  = 3'd2,
    ST_F_REL = 3'd3,
    ST_E_LO  = 3'd4,
    ST_E_HI  = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ackLow;
    logic ackHigh;
    logic dataLow;
    logic dataRelease;
    logic cycleClear;
    logic cycleInc;
    logic pollClear;
    logic pollInc;
    logic doneSet;
    logic timeoutSet;
  } hlfStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic clkLvl;
    logic dataLvl;
    logic cycleLast;
    logic pollExpired;
  } hlfStatus_t;

endpackage

// File: rtl/hlf_sync.sv
module hlf_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hlf_datapath.sv
module hlf_datapath
  import hlf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 36,
  parameter int POLL_LIMIT   = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkClk,
  input  logic       linkData,
  input  hlfStrobe_t strobe,
  output hlfStatus_t status,
  output logic       linkAck,
  output logic       linkDataLow,
  output logic       done,
  output logic       timeout
);

  localparam int CYC_W  = $clog2(FLUSH_CYCLES + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic              clkSync;
  logic              dataSync;
  logic              ackQ;
  logic              dataLowQ;
  logic              doneQ;
  logic              timeoutQ;
  logic [CYC_W-1:0]  cycleCnt;
  logic [POLL_W-1:0] pollCnt;

  hlf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uClkSync (
    .clk(clk), .rstN(rstN), .din(linkClk), .dout(clkSync)
  );

  hlf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uDataSync (
    .clk(clk), .rstN(rstN), .din(linkData), .dout(dataSync)
  );

  // acknowledge line, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ackQ <= 1'b1;
    else if (strobe.ackLow)  ackQ <= 1'b0;
    else if (strobe.ackHigh) ackQ <= 1'b1;
  end

  // open-drain pull-down enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   dataLowQ <= 1'b0;
    else if (strobe.dataRelease) dataLowQ <= 1'b0;
    else if (strobe.dataLow)     dataLowQ <= 1'b1;
  end

  // completed flusher handshakes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cycleCnt <= '0;
    else if (strobe.cycleClear) cycleCnt <= '0;
    else if (strobe.cycleInc)   cycleCnt <= cycleCnt + 1'b1;
  end

  // polls spent in the current wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pollCnt <= '0;
    else if (strobe.pollClear) pollCnt <= '0;
    else if (strobe.pollInc)   pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      doneQ    <= strobe.doneSet;
      timeoutQ <= strobe.timeoutSet;
    end
  end

  assign status.clkLvl      = clkSync;
  assign status.dataLvl     = dataSync;
  assign status.cycleLast   = (cycleCnt == CYC_W'(FLUSH_CYCLES - 1));
  assign status.pollExpired = (pollCnt == POLL_W'(POLL_LIMIT - 1));

  assign linkAck     = ackQ;
  assign linkDataLow = dataLowQ;
  assign done        = doneQ;
  assign timeout     = timeoutQ;

  AST_ACK_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackQ) |-> !$past(clkSync));  // R8

  AST_ACK_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> ($past(clkSync) || timeoutQ));  // R4

  AST_RELEASE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataLowQ) |-> ((cycleCnt == CYC_W'(FLUSH_CYCLES)) || timeoutQ));  // R3

  AST_DONE_ACK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (ackQ && !timeoutQ));  // R5

  AST_TIMEOUT_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    timeoutQ |-> (ackQ && !dataLowQ));  // R7

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);  // R5

endmodule

// File: rtl/hlf_control.sv
module hlf_control
  import hlf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startFlush,
  input  logic       startFlushee,
  input  hlfStatus_t status,
  output hlfStrobe_t strobe,
  output logic       busy
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // common fallback for a wait whose level has not arrived yet
  function automatic void waitMore(inout hlfStrobe_t s, inout seqState_t nx, input logic expired);
    if (expired) begin
      s.timeoutSet  = 1'b1;
      s.ackHigh     = 1'b1;
      s.dataRelease = 1'b1;
      s.pollClear   = 1'b1;
      nx            = ST_IDLE;
    end else begin
      s.pollInc = 1'b1;
    end
  endfunction

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startFlush) begin
          strobe.dataLow    = 1'b1;
          strobe.cycleClear = 1'b1;
          strobe.pollClear  = 1'b1;
          nextState         = ST_F_LO;
        end else if (startFlushee) begin
          strobe.pollClear  = 1'b1;
          nextState         = ST_E_LO;
        end
      end
      ST_F_LO: begin
        if (!status.clkLvl) begin
          strobe.ackLow    = 1'b1;
          strobe.pollClear = 1'b1;
          nextState        = ST_F_HI;
        end else begin
          waitMore(strobe, nextState, status.pollExpired);
        end
      end
      ST_F_HI: begin
        if (status.clkLvl) begin
          strobe.ackHigh   = 1'b1;
          strobe.cycleInc  = 1'b1;
          strobe.pollClear = 1'b1;
          nextState        = status.cycleLast ? ST_F_REL : ST_F_LO;
        end else begin
          waitMore(strobe, nextState, status.pollExpired);
        end
      end
      ST_F_REL: begin
        if (!status.clkLvl) begin
          strobe.dataRelease = 1'b1;
          strobe.pollClear   = 1'b1;
          nextState          = ST_E_LO;
        end else begin
          waitMore(strobe, nextState, status.pollExpired);
        end
      end
      ST_E_LO: begin
        if (!status.clkLvl) begin
          strobe.ackLow    = 1'b1;
          strobe.pollClear = 1'b1;
          nextState        = ST_E_HI;
        end else begin
          waitMore(strobe, nextState, status.pollExpired);
        end
      end
      ST_E_HI: begin
        if (status.clkLvl) begin
          strobe.ackHigh   = 1'b1;
          strobe.pollClear = 1'b1;
          if (status.dataLvl) begin
            strobe.doneSet = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            nextState      = ST_E_LO;
          end
        end else begin
          waitMore(strobe, nextState, status.pollExpired);
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    state inside {ST_IDLE, ST_F_LO, ST_F_HI, ST_F_REL, ST_E_LO, ST_E_HI});  // R1

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_E_HI && state == ST_E_LO) |-> !strobe.dataLow);  // R9

  AST_ACK_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ackLow && strobe.ackHigh));  // R4

endmodule

// File: rtl/hlf_top.sv
module hlf_top
  import hlf_pkg::*;
#(
  parameter int FLUSH_CYCLES = 36,
  parameter int POLL_LIMIT   = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startFlush,
  input  logic startFlushee,
  input  logic linkClk,
  input  logic linkData,
  output logic linkAck,
  output logic linkDataLow,
  output logic busy,
  output logic done,
  output logic timeout
);

  hlfStrobe_t strobe;
  hlfStatus_t status;

  hlf_control uCtrl (
    .clk(clk), .rstN(rstN),
    .startFlush(startFlush), .startFlushee(startFlushee),
    .status(status), .strobe(strobe), .busy(busy)
  );

  hlf_datapath #(
    .FLUSH_CYCLES(FLUSH_CYCLES), .POLL_LIMIT(POLL_LIMIT), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .linkClk(linkClk), .linkData(linkData),
    .strobe(strobe), .status(status),
    .linkAck(linkAck), .linkDataLow(linkDataLow),
    .done(done), .timeout(timeout)
  );

endmodule

// File: tb/tb_hlf_top.sv
`timescale 1ns/1ps
module tb_hlf_top;

  localparam int FLUSH = 4;
  localparam int POLL  = 64;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startFlush = 1'b0;
  logic startFlushee = 1'b0;
  logic guestClk = 1'b1;
  logic guestLow = 1'b0;
  logic linkAck, linkDataLow, busy, done, timeout;
  logic lineData;

  int checks = 0;
  int errors = 0;

  assign lineData = !(linkDataLow || guestLow);

  always #2.5 clk = ~clk;

  hlf_top #(.FLUSH_CYCLES(FLUSH), .POLL_LIMIT(POLL), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .startFlush(startFlush), .startFlushee(startFlushee),
    .linkClk(guestClk), .linkData(lineData), .linkAck(linkAck),
    .linkDataLow(linkDataLow), .busy(busy), .done(done), .timeout(timeout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitAck(input logic val, output int lat);
    lat = 0;
    while (linkAck !== val && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // one guest-driven handshake; guest data level at P3 given by lowAtP3
  task automatic hsCycle(input bit lowAtP3, input bit expDone, input bit expHostLow);
    int lat;
    guestClk = 1'b0;
    waitAck(1'b0, lat);
    check(lat == LAT, "R8 ack fall latency", lat, LAT);
    guestLow = lowAtP3;
    guestClk = 1'b1;
    check(linkDataLow == expHostLow, "R2/R6 host data drive in P3", linkDataLow, expHostLow);
    waitAck(1'b1, lat);
    check(lat == LAT, "R8 ack rise latency", lat, LAT);
    check(done == expDone, "R4/R5 done at ack rise", done, expDone);
    if (expDone) begin
      check(busy == 1'b0, "R5 idle after done", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", done, 0);
      guestLow = 1'b0;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int first;
    repeat (5) @(negedge clk);
    check(linkAck == 1'b1, "R1 reset ack", linkAck, 1);
    check(linkDataLow == 1'b0, "R1 reset data", linkDataLow, 0);
    check({busy, done, timeout} == 3'b000, "R1 reset flags", {busy, done, timeout}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // host-started flush, guest holding data low k extra cycles
    for (int k = 0; k < 4; k++) begin
      startFlush = 1'b1;
      @(negedge clk);
      startFlush = 1'b0;
      check(linkDataLow == 1'b1, "R2 data low on start", linkDataLow, 1);
      check(busy == 1'b1, "R2 busy on start", busy, 1);
      for (int c = 0; c < FLUSH; c++) hsCycle(1'b0, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      check(linkDataLow == 1'b1, "R3 not released before clock fall", linkDataLow, 1);
      guestClk = 1'b0;
      waitAck(1'b0, lat);
      check(lat == LAT + 1, "R3 release-cycle ack latency", lat, LAT + 1);
      check(linkDataLow == 1'b0, "R3 released before ack fall", linkDataLow, 0);
      guestLow = (k > 0);
      guestClk = 1'b1;
      waitAck(1'b1, lat);
      check(lat == LAT, "R8 ack rise latency", lat, LAT);
      check(done == (k == 0), "R4/R5 done after release cycle", done, (k == 0));
      if (k == 0) begin
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
      end
      for (int j = 1; j <= k; j++) hsCycle(j < k, j == k, 1'b0);
      check(busy == 1'b0, "R5 idle at end of flush", busy, 0);
      repeat (4) @(negedge clk);
    end

    // guest-started flush with n low cycles
    for (int n = 0; n < 5; n++) begin
      guestLow = (n > 0);
      startFlushee = 1'b1;
      @(negedge clk);
      startFlushee = 1'b0;
      check(busy == 1'b1, "R6 busy on flushee start", busy, 1);
      for (int j = 0; j <= n; j++) begin
        if (n == 2 && j == 1) begin
          startFlush = 1'b1;
          @(negedge clk);
          startFlush = 1'b0;
          @(negedge clk);
          check(linkDataLow == 1'b0, "R9 start while busy ignored", linkDataLow, 0);
        end
        hsCycle(j < n, j == n, 1'b0);
      end
      check(busy == 1'b0, "R6 done after n+1 handshakes", busy, 0);
      repeat (4) @(negedge clk);
    end

    // timeout waiting in phase 0
    startFlush = 1'b1;
    first = 0;
    for (int i = 1; i <= POLL + 3; i++) begin
      @(negedge clk);
      startFlush = 1'b0;
      if (timeout && first == 0) first = i;
    end
    check(first == POLL + 1, "R7 timeout in phase 0 timing", first, POLL + 1);
    check(timeout == 1'b0, "R7 timeout single pulse", timeout, 0);
    check({linkAck, linkDataLow, busy} == 3'b100, "R7 idle after timeout", {linkAck, linkDataLow, busy}, 4);

    // timeout waiting in phase 2
    startFlushee = 1'b1;
    @(negedge clk);
    startFlushee = 1'b0;
    guestClk = 1'b0;
    waitAck(1'b0, lat);
    check(lat == LAT, "R8 ack fall latency", lat, LAT);
    first = 0;
    for (int i = 1; i <= POLL + 3; i++) begin
      @(negedge clk);
      if (timeout && first == 0) first = i;
    end
    check(first == POLL, "R7 timeout in phase 2 timing", first, POLL);
    check({linkAck, linkDataLow, busy} == 3'b100, "R7 idle after timeout", {linkAck, linkDataLow, busy}, 4);
    guestClk = 1'b1;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule